// File: doc/BRIEF.md
# Supply Droop Guard

This block sits beside three comparators that watch the system supply and report, each on one digital line, that the supply has fallen below a programmed level: an early warning ("warn A"), a deeper warning ("warn B") and a critical level. Each channel's comparator line is synchronised and then filtered by a debounce counter. The filtered ("live") channel state is readable by software. Its rising edge latches an interrupt flag, and the flags can be masked individually before they reach the single interrupt line.

The live states also drive four protective outputs: a disable line for each warning channel, a critical disable line and a processor-throttle line. Each output has a behaviour register that says whether it may assert and whether it is sticky. A non-sticky output follows its condition. A sticky output stays asserted after the supply recovers until software writes 1 to its bit in the output status register. Each channel's 3-bit threshold code is forwarded on a port to the reference generator outside this block. Code 0 selects the highest trip level, and each step lowers the level by 100 mV. Software reaches every register over a byte-wide bus with a single-cycle write strobe and a combinational read.

Top module: `vdrop_guard`

Register map (4-bit address): 0x0 live status (read-only), 0x1 interrupt flags (write 1 to clear), 0x2 interrupt mask, 0x3 output status (write 1 to clear), 0x4 warn B config, 0x5 warn A config, 0x6 critical config, 0x8 throttle behaviour, 0x9 critical-disable behaviour, 0xA disable-B behaviour, 0xB disable-A behaviour. Unlisted addresses read 0.

## Requirements
- R1: After reset every output pin is 0 and the registers read: status, flags, mask and output status 0x00; warn A and warn B config 0x78; critical config 0x18; throttle behaviour 0x06; critical-disable behaviour 0x00; disable-A and disable-B behaviour 0x05.
- R2: Bits [2:0] of each config register appear on thr_code_o: warn B on [2:0], warn A on [5:3], critical on [8:6].
- R3: Config bit 3 enables a channel. While it is 0, the channel's live status stays 0 and its interrupt flag is never set, whatever its comparator line does.
- R4: A live status bit takes the new comparator level SYNC_STAGES + L clock edges after the line changes. For warn A and warn B, L comes from config bits [6:4] as field 0..7 -> 1, 2, 5, 8, 11, 14, 17, 20 cycles. For the critical channel, L is CRIT_DBNC (default 4).
- R5: A comparator pulse shorter than the debounce length leaves the live status and the flags unchanged, because the count restarts whenever the line returns to the current state.
- R6: The live status register and the flag register use the same bit order: bit 0 warn B, bit 1 warn A, bit 2 critical. A flag is set when its live status goes from 0 to 1. It stays set until software writes 1 to it, and a flag cleared while its status is still high stays clear.
- R7: Mask register bits use the same order as the flags, and 1 means masked. irq_o is high exactly when some flag is set whose mask bit is 0. Masked flags still latch.
- R8: For disable-A and disable-B, behaviour bit 0 allows the output to assert and bit 2 makes it sticky. An allowed output goes high one clock edge after its channel's live status goes high.
- R9: A non-sticky output falls one clock edge after its condition ends.
- R10: A sticky output stays high after its condition ends until 1 is written to its output status bit (bit 0 throttle, bit 1 critical disable, bit 2 disable B, bit 3 disable A). Writing 1 while the condition persists, or writing 1 to other bits, leaves it high.
- R11: Throttle behaviour bit 0 lets either warning channel assert throttle_o, bit 1 lets the critical channel assert it, and bit 2 makes it sticky.
- R12: dis_crit_o asserts only when critical-disable behaviour bit 0 and critical config bit 4 (shutdown enable) are both 1.
- R13: Only defined fields are stored. Writing 0xFF reads back 0x7F for warning configs, 0x1F for the critical config, 0x07 for the throttle behaviour and the mask, and 0x05 for the disable behaviours. Writes to the live status register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_raw_i | input | 3 | Raw comparator lines: bit 0 warn B, bit 1 warn A, bit 2 critical |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i (combinational) |
| thr_code_o | output | 9 | Threshold codes for the reference generator |
| irq_o | output | 1 | Interrupt, OR of unmasked flags |
| dis_a_o | output | 1 | Warn A disable line |
| dis_b_o | output | 1 | Warn B disable line |
| dis_crit_o | output | 1 | Critical disable line |
| throttle_o | output | 1 | Processor-throttle line |

## Verification
The hardest case to reach is a sticky output being held by its own condition while software tries to clear it. The clear write has to land while the comparator line is still high, and the checks must then show that the output survives both that write and the recovery of the supply, and falls only on a second clear. The bench gets there by holding the comparator line across the first clear, dropping it, waiting out the debounce, and only then writing the clear again. The debounce is swept over all eight codes with exact edge counts, so an off-by-one in the count or the synchroniser shows up at once.

// File: rtl/vdrop_pkg.sv
package vdrop_pkg;

  localparam int NCH  = 3;  // channel index == status bit
  localparam int CH_WB = 0;
  localparam int CH_WA = 1;
  localparam int CH_CR = 2;

  localparam int NOUT = 4;  // output index == output-status bit
  localparam int O_THR = 0;
  localparam int O_DCR = 1;
  localparam int O_DB  = 2;
  localparam int O_DA  = 3;

  localparam int A_STATUS   = 0;
  localparam int A_FLAGS    = 1;
  localparam int A_MASK     = 2;
  localparam int A_OUTSTAT  = 3;
  localparam int A_CFG_BASE = 4;
  localparam int A_BEH_BASE = 8;

  localparam int LEN_W = 5;

  // Debounce length for a 3-bit field: 1 for 0, otherwise 3*f-1.
  function automatic logic [LEN_W-1:0] dbnc_cycles(input logic [2:0] f);
    logic [LEN_W-1:0] t;
    t = {{(LEN_W-3){1'b0}}, f};
    if (f == 3'd0) return LEN_W'(1);
    return t + t + t - LEN_W'(1);
  endfunction

  function automatic logic [7:0] cfg_keep(input int ch);
    return (ch == CH_CR) ? 8'h1F : 8'h7F;
  endfunction

  function automatic logic [7:0] cfg_rst(input int ch);
    return (ch == CH_CR) ? 8'h18 : 8'h78;
  endfunction

  function automatic logic [7:0] beh_keep(input int o);
    return (o == O_THR) ? 8'h07 : 8'h05;
  endfunction

  function automatic logic [7:0] beh_rst(input int o);
    case (o)
      O_THR:   return 8'h06;
      O_DCR:   return 8'h00;
      default: return 8'h05;
    endcase
  endfunction

  // Next value of a protective output.
  function automatic logic out_next(input logic cause, input logic sticky,
                                    input logic cur, input logic clr);
    return cause | (sticky & cur & ~clr);
  endfunction

endpackage

// File: rtl/vdrop_debounce.sv
module vdrop_debounce #(
  parameter int SYNC_STAGES = 2,
  parameter int LEN_W       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             raw_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             state_o,
  output logic             rise_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [LEN_W-1:0]       cnt_q;
  logic                   state_q;
  logic                   sampled;
  logic                   differs;
  logic                   done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
  end

  assign sampled = sync_q[SYNC_STAGES-1];
  assign differs = sampled != state_q;
  assign done    = cnt_q >= (len_i - LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!enable_i) begin
      state_q <= 1'b0;
      cnt_q   <= '0;
    end else if (differs) begin
      if (done) begin
        state_q <= sampled;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + LEN_W'(1);
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign state_o = state_q;
  assign rise_o  = enable_i & differs & sampled & done;

endmodule

// File: rtl/vdrop_outlatch.sv
module vdrop_outlatch (
  input  logic clk,
  input  logic rst_n,
  input  logic cause_i,
  input  logic sticky_i,
  input  logic clr_i,
  output logic out_o
);
  import vdrop_pkg::*;

  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_next(cause_i, sticky_i, out_q, clr_i);
  end

  assign out_o = out_q;

endmodule

// File: rtl/vdrop_guard.sv
module vdrop_guard
  import vdrop_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CRIT_DBNC   = 4,
  parameter int ADDR_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    cmp_raw_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  output logic [3*NCH-1:0]  thr_code_o,
  output logic              irq_o,
  output logic              dis_a_o,
  output logic              dis_b_o,
  output logic              dis_crit_o,
  output logic              throttle_o
);

  logic [7:0]      cfg_q [NCH];
  logic [7:0]      beh_q [NOUT];
  logic [NCH-1:0]  flag_q;
  logic [NCH-1:0]  mask_q;
  logic [NCH-1:0]  live_st;
  logic [NCH-1:0]  rise;
  logic [NCH-1:0]  ch_en;
  logic [NCH-1:0]  flag_clr;
  logic [NOUT-1:0] out_cause;
  logic [NOUT-1:0] out_sticky;
  logic [NOUT-1:0] out_clr;
  logic [NOUT-1:0] out_q;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int target);
    return a == ADDR_W'(target);
  endfunction

  // Register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++)  cfg_q[c] <= cfg_rst(c);
      for (int o = 0; o < NOUT; o++) beh_q[o] <= beh_rst(o);
      mask_q <= '0;
    end else if (bus_we_i) begin
      for (int c = 0; c < NCH; c++)
        if (hit(bus_addr_i, A_CFG_BASE + c)) cfg_q[c] <= bus_wdata_i & cfg_keep(c);
      for (int o = 0; o < NOUT; o++)
        if (hit(bus_addr_i, A_BEH_BASE + o)) beh_q[o] <= bus_wdata_i & beh_keep(o);
      if (hit(bus_addr_i, A_MASK)) mask_q <= bus_wdata_i[NCH-1:0];
    end
  end

  // Channels
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [LEN_W-1:0] len;
    if (c == CH_CR) begin : g_fixed
      assign len = LEN_W'(CRIT_DBNC);
    end else begin : g_prog
      assign len = dbnc_cycles(cfg_q[c][6:4]);
    end
    assign ch_en[c] = cfg_q[c][3];
    assign thr_code_o[3*c +: 3] = cfg_q[c][2:0];

    vdrop_debounce #(.SYNC_STAGES(SYNC_STAGES), .LEN_W(LEN_W)) u_dbnc (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable_i (ch_en[c]),
      .raw_i    (cmp_raw_i[c]),
      .len_i    (len),
      .state_o  (live_st[c]),
      .rise_o   (rise[c])
    );
  end

  // Interrupt flags
  assign flag_clr = (bus_we_i && hit(bus_addr_i, A_FLAGS)) ? bus_wdata_i[NCH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~flag_clr) | rise;
  end

  assign irq_o = |(flag_q & ~mask_q);

  // Protective outputs
  always_comb begin
    out_cause[O_THR] = (beh_q[O_THR][0] & (live_st[CH_WA] | live_st[CH_WB]))
                     | (beh_q[O_THR][1] & live_st[CH_CR]);
    out_cause[O_DCR] = beh_q[O_DCR][0] & live_st[CH_CR] & cfg_q[CH_CR][4];
    out_cause[O_DB]  = beh_q[O_DB][0]  & live_st[CH_WB];
    out_cause[O_DA]  = beh_q[O_DA][0]  & live_st[CH_WA];
  end

  for (genvar o = 0; o < NOUT; o++) begin : g_out
    assign out_sticky[o] = beh_q[o][2];
    assign out_clr[o]    = bus_we_i & hit(bus_addr_i, A_OUTSTAT) & bus_wdata_i[o];

    vdrop_outlatch u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .cause_i  (out_cause[o]),
      .sticky_i (out_sticky[o]),
      .clr_i    (out_clr[o]),
      .out_o    (out_q[o])
    );
  end

  assign throttle_o = out_q[O_THR];
  assign dis_crit_o = out_q[O_DCR];
  assign dis_b_o    = out_q[O_DB];
  assign dis_a_o    = out_q[O_DA];

  // Read mux
  always_comb begin
    bus_rdata_o = 8'h00;
    if (hit(bus_addr_i, A_STATUS))  bus_rdata_o = 8'(live_st);
    if (hit(bus_addr_i, A_FLAGS))   bus_rdata_o = 8'(flag_q);
    if (hit(bus_addr_i, A_MASK))    bus_rdata_o = 8'(mask_q);
    if (hit(bus_addr_i, A_OUTSTAT)) bus_rdata_o = 8'(out_q);
    for (int c = 0; c < NCH; c++)
      if (hit(bus_addr_i, A_CFG_BASE + c)) bus_rdata_o = cfg_q[c];
    for (int o = 0; o < NOUT; o++)
      if (hit(bus_addr_i, A_BEH_BASE + o)) bus_rdata_o = beh_q[o];
  end

endmodule

// File: rtl/vdrop_guard_chk.sv
module vdrop_guard_chk
  import vdrop_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [NCH-1:0]  live_st,
  input logic [NCH-1:0]  ch_en,
  input logic [NCH-1:0]  flag_q,
  input logic [NCH-1:0]  flag_clr,
  input logic            irq_o,
  input logic [NOUT-1:0] out_q,
  input logic [NOUT-1:0] out_cause,
  input logic [NOUT-1:0] out_sticky,
  input logic [NOUT-1:0] out_clr
);

  assert_irq_has_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flag_q != '0));

  for (genvar c = 0; c < NCH; c++) begin : g_chk_ch
    assert_rise_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(live_st[c]) |-> flag_q[c]);
    assert_flag_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[c] && !flag_clr[c]) |=> flag_q[c]);
    assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[c] |=> !live_st[c]);
  end

  for (genvar o = 0; o < NOUT; o++) begin : g_chk_out
    assert_cause_asserts_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_cause[o] |=> out_q[o]);
    assert_nonsticky_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_sticky[o] && !out_cause[o]) |=> !out_q[o]);
    assert_sticky_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_q[o] && out_sticky[o] && !out_clr[o]) |=> out_q[o]);
  end

endmodule

bind vdrop_guard vdrop_guard_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .live_st    (live_st),
  .ch_en      (ch_en),
  .flag_q     (flag_q),
  .flag_clr   (flag_clr),
  .irq_o      (irq_o),
  .out_q      (out_q),
  .out_cause  (out_cause),
  .out_sticky (out_sticky),
  .out_clr    (out_clr)
);

// File: tb/vdrop_guard_bench.sv
`timescale 1ns/1ps
module vdrop_guard_bench;

  localparam int SYNC = 2;
  localparam int CRIT_LEN = 4;
  localparam logic [3:0] R_ST = 4'h0, R_FL = 4'h1, R_MK = 4'h2, R_OS = 4'h3,
                         R_CB = 4'h4, R_CA = 4'h5, R_CC = 4'h6,
                         R_BT = 4'h8, R_BC = 4'h9, R_BB = 4'hA, R_BA = 4'hB;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] raw = '0;
  logic       we = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [8:0] thr;
  logic       irq, dis_a, dis_b, dis_c, thrott;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  vdrop_guard u_vdrop_guard (
    .clk(clk), .rst_n(rst_n), .cmp_raw_i(raw), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .thr_code_o(thr), .irq_o(irq), .dis_a_o(dis_a), .dis_b_o(dis_b),
    .dis_crit_o(dis_c), .throttle_o(thrott)
  );

  function automatic int len_of(input int f);
    case (f)
      0: return 1;  1: return 2;  2: return 5;  3: return 8;
      4: return 11; 5: return 14; 6: return 17; default: return 20;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    cyc(1);

    // R1 reset values
    rd(R_ST, d); chk("R1 status", d, 8'h00);
    rd(R_FL, d); chk("R1 flags", d, 8'h00);
    rd(R_MK, d); chk("R1 mask", d, 8'h00);
    rd(R_OS, d); chk("R1 outstat", d, 8'h00);
    rd(R_CB, d); chk("R1 cfgB", d, 8'h78);
    rd(R_CA, d); chk("R1 cfgA", d, 8'h78);
    rd(R_CC, d); chk("R1 cfgC", d, 8'h18);
    rd(R_BT, d); chk("R1 behT", d, 8'h06);
    rd(R_BC, d); chk("R1 behC", d, 8'h00);
    rd(R_BB, d); chk("R1 behB", d, 8'h05);
    rd(R_BA, d); chk("R1 behA", d, 8'h05);
    chk("R1 pins", {irq, dis_a, dis_b, dis_c, thrott}, 0);
    chk("R1 thr", thr, 0);

    // R2 threshold codes
    for (int c = 0; c < 8; c++) begin
      wr(R_CA, 8'h08 | 8'(c));
      wr(R_CB, 8'h08 | 8'(7 - c));
      chk("R2 thrA", thr[5:3], c);
      chk("R2 thrB", thr[2:0], 7 - c);
      chk("R2 thrC", thr[8:6], 0);
    end

    // R4 debounce sweep on warn A (outputs quiet)
    wr(R_BA, 8'h00); wr(R_BB, 8'h00); wr(R_BT, 8'h00);
    for (int f = 0; f < 8; f++) begin
      int n;
      n = SYNC + len_of(f);
      wr(R_CA, 8'h08 | 8'(f << 4));
      @(negedge clk); raw[1] = 1'b1;
      cyc(n - 1); rd(R_ST, d); chk("R4 early", d[1], 0);
      cyc(1);     rd(R_ST, d); chk("R4 onset", d[1], 1);
      raw[1] = 1'b0;
      cyc(n - 1); rd(R_ST, d); chk("R4 fall early", d[1], 1);
      cyc(1);     rd(R_ST, d); chk("R4 fall", d[1], 0);
      rd(R_FL, d); chk("R6 flagA", d, 8'h02);
      wr(R_FL, 8'h07);
    end

    // R4 critical fixed length, R6 bit position
    @(negedge clk); raw[2] = 1'b1;
    cyc(SYNC + CRIT_LEN - 1); rd(R_ST, d); chk("R4 crit early", d[2], 0);
    cyc(1); rd(R_ST, d); chk("R4 crit onset", d, 8'h04);
    rd(R_FL, d); chk("R6 flagC", d, 8'h04);
    chk("R7 irq crit", irq, 1);
    raw[2] = 1'b0; cyc(10);
    wr(R_FL, 8'h04); rd(R_FL, d); chk("R6 w1c", d, 8'h00);

    // warn B with default-ish length 20
    wr(R_CB, 8'h78);
    @(negedge clk); raw[0] = 1'b1; cyc(30);
    rd(R_ST, d); chk("R6 statusB", d, 8'h01);
    rd(R_FL, d); chk("R6 flagB", d, 8'h01);
    raw[0] = 1'b0; cyc(30);
    wr(R_FL, 8'h07);

    // R5 glitch filter: len 8, pulse 5
    wr(R_CA, 8'h38);
    @(negedge clk); raw[1] = 1'b1; cyc(5); raw[1] = 1'b0; cyc(30);
    rd(R_ST, d); chk("R5 status", d, 8'h00);
    rd(R_FL, d); chk("R5 flags", d, 8'h00);

    // R7 masking
    wr(R_CA, 8'h18);
    wr(R_MK, 8'h07);
    @(negedge clk); raw[1] = 1'b1; cyc(10);
    rd(R_FL, d); chk("R7 masked latch", d, 8'h02);
    chk("R7 masked irq", irq, 0);
    wr(R_MK, 8'h05); chk("R7 unmasked irq", irq, 1);
    wr(R_FL, 8'h02); cyc(5);
    rd(R_FL, d); chk("R6 cleared while high", d, 8'h00);
    chk("R7 irq after clear", irq, 0);
    raw[1] = 1'b0; cyc(10);
    wr(R_MK, 8'h00);

    // R3 disabled channel
    wr(R_CB, 8'h70);
    @(negedge clk); raw[0] = 1'b1; cyc(40);
    rd(R_ST, d); chk("R3 status", d, 8'h00);
    rd(R_FL, d); chk("R3 flags", d, 8'h00);
    raw[0] = 1'b0; wr(R_CB, 8'h18); cyc(10);

    // R8/R9 non-sticky disable A (len 2)
    wr(R_BA, 8'h01);
    @(negedge clk); raw[1] = 1'b1;
    cyc(SYNC + 2); rd(R_ST, d); chk("R8 status up", d[1], 1);
    chk("R8 not yet", dis_a, 0);
    cyc(1); chk("R8 dis_a", dis_a, 1);
    rd(R_OS, d); chk("R8 outstat", d, 8'h08);
    raw[1] = 1'b0;
    cyc(SYNC + 2); rd(R_ST, d); chk("R9 status down", d[1], 0);
    chk("R9 still", dis_a, 1);
    cyc(1); chk("R9 drop", dis_a, 0);
    wr(R_FL, 8'h07);

    // R10 sticky disable A
    wr(R_BA, 8'h05);
    @(negedge clk); raw[1] = 1'b1; cyc(10);
    chk("R10 up", dis_a, 1);
    wr(R_OS, 8'h08); cyc(1); chk("R10 clear while active", dis_a, 1);
    raw[1] = 1'b0; cyc(10);
    chk("R10 held", dis_a, 1);
    wr(R_OS, 8'h07); cyc(1); chk("R10 other bits", dis_a, 1);
    wr(R_OS, 8'h08); chk("R10 cleared", dis_a, 0);
    rd(R_OS, d); chk("R10 outstat", d, 8'h00);

    // R10 sticky disable B
    wr(R_BB, 8'h05);
    @(negedge clk); raw[0] = 1'b1; cyc(10);
    rd(R_OS, d); chk("R10 outstat B", d, 8'h04);
    raw[0] = 1'b0; cyc(10);
    chk("R10 B held", dis_b, 1);
    wr(R_OS, 8'h04); chk("R10 B cleared", dis_b, 0);
    wr(R_BA, 8'h00); wr(R_BB, 8'h00); wr(R_FL, 8'h07);

    // R11 throttle enables
    wr(R_BT, 8'h01);
    @(negedge clk); raw[1] = 1'b1; cyc(10);
    chk("R11 warn throttle", thrott, 1);
    rd(R_OS, d); chk("R11 outstat", d, 8'h01);
    raw[1] = 1'b0; cyc(10); chk("R11 release", thrott, 0);
    raw[2] = 1'b1; cyc(12); chk("R11 crit blocked", thrott, 0);
    raw[2] = 1'b0; cyc(12);
    wr(R_BT, 8'h02);
    raw[2] = 1'b1; cyc(12); chk("R11 crit throttle", thrott, 1);
    raw[0] = 1'b0; raw[2] = 1'b0; cyc(12); chk("R11 crit release", thrott, 0);
    raw[1] = 1'b1; cyc(10); chk("R11 warn blocked", thrott, 0);
    raw[1] = 1'b0; cyc(10);
    wr(R_BT, 8'h00); wr(R_FL, 8'h07);

    // R12 critical disable needs shutdown enable
    wr(R_BC, 8'h01); wr(R_CC, 8'h08);
    @(negedge clk); raw[2] = 1'b1; cyc(12);
    rd(R_ST, d); chk("R12 status", d, 8'h04);
    chk("R12 gated", dis_c, 0);
    wr(R_CC, 8'h18); cyc(1); chk("R12 enabled", dis_c, 1);
    raw[2] = 1'b0; cyc(12); chk("R12 release", dis_c, 0);
    wr(R_BC, 8'h00); wr(R_FL, 8'h07);

    // R13 storage masks
    wr(R_CB, 8'hFF); rd(R_CB, d); chk("R13 cfgB", d, 8'h7F);
    wr(R_CA, 8'hFF); rd(R_CA, d); chk("R13 cfgA", d, 8'h7F);
    wr(R_CC, 8'hFF); rd(R_CC, d); chk("R13 cfgC", d, 8'h1F);
    wr(R_BT, 8'hFF); rd(R_BT, d); chk("R13 behT", d, 8'h07);
    wr(R_BC, 8'hFF); rd(R_BC, d); chk("R13 behC", d, 8'h05);
    wr(R_BB, 8'hFF); rd(R_BB, d); chk("R13 behB", d, 8'h05);
    wr(R_BA, 8'hFF); rd(R_BA, d); chk("R13 behA", d, 8'h05);
    wr(R_MK, 8'hFF); rd(R_MK, d); chk("R13 mask", d, 8'h07);
    wr(R_ST, 8'hFF); rd(R_ST, d); chk("R13 status ro", d, 8'h00);
    chk("R13 pins idle", {dis_a, dis_b, dis_c, thrott}, 0);

    finished = 1;
    summary();
    $finish;
  end

endmodule